// File: doc/BRIEF.md
# Mute and Power-Up Sequencer

This block is the control state machine of a two-channel digital volume stage. It holds the output stage disconnected through a power-on hold period and then through an offset calibration, after which it clears both channel gain bytes. It then runs the hardware mute cycle. A mute request disconnects the output only at a zero crossing or after a time-out, and it always triggers a new calibration. Release of the mute waits the same way before the output is reconnected. A loss of supply sends the block back to the start of the power-up sequence.

Each channel also has a software mute. A gain byte of zero puts that channel's amplifier into a unity-gain, grounded-input mode, shown on a per-channel mode output. This change is gated by that channel's zero crossing, by a time-out, or by nothing when zero-crossing gating is turned off. All periods are counted in clock cycles and set by parameters. The analog parts are present only as flags and handshakes: comparators, termination and the calibration engine.

Top module: `mps_sequencer`

## Requirements
- R1: While `rst_n` is low, and for `PUP_CYCLES` clock cycles after it rises with `supply_ok` high, `seq_state` reads 0 (power hold) and `out_disconnect` is high. `cal_start` and `gain_clear` are low, and every `soft_mute` bit is high.
- R2: At the end of the power hold the state becomes 1 (power calibration). `cal_start` is high for exactly the first cycle of that state.
- R3: `cal_done` high in state 1 moves the block to state 2 (run) at the next edge. `gain_clear` is high for exactly the first run cycle, and `out_disconnect` goes low.
- R4: `hw_mute` high in run moves the block to state 3 (mute pending) with the output still connected. If `hw_mute` drops while the block is pending, it returns to run.
- R5: From state 3 the block moves to state 4 (mute calibration). It does so at the edge where every channel has shown a `zc_det` pulse since entering state 3, or after `ZC_TIMEOUT` cycles in state 3, whichever comes first. This holds whatever the value of `zc_gate_en`.
- R6: Entering state 4 sets `out_disconnect` high and pulses `cal_start` for one cycle. `cal_done` then moves the block to state 5 (muted).
- R7: `hw_mute` low in state 5 moves the block to state 6 (unmute pending), where the output stays disconnected. It returns to run once every channel has shown a zero crossing, or after `ZC_TIMEOUT` cycles. `hw_mute` high in state 6 returns the block to state 5.
- R8: `supply_ok` low in any state puts the block in state 0 with the output disconnected at the next edge. The power hold restarts its `PUP_CYCLES` count when `supply_ok` returns high.
- R9: Channel i has gain byte `gain_bytes[i*GAIN_W +: GAIN_W]`, and `soft_mute[i]` follows whether that byte is zero. With `zc_gate_en` high, a change is applied at the edge where `zc_det[i]` is high, or after `ZC_TIMEOUT` cycles of pending change.
- R10: With `zc_gate_en` low, a change of a channel's zero-gain condition reaches `soft_mute` at the next edge.
- R11: In state 0 every `soft_mute` bit is forced high, whatever the gain bytes are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply-good flag, synchronous |
| hw_mute | input | 1 | Hardware mute request |
| zc_gate_en | input | 1 | Zero-crossing gating enable for software mute changes |
| zc_det | input | NCH | Per-channel zero-crossing pulse |
| gain_bytes | input | NCH*GAIN_W | Current gain byte of each channel, channel 0 lowest |
| cal_done | input | 1 | Offset calibration finished |
| out_disconnect | output | 1 | Output stage disconnected and terminated |
| cal_start | output | 1 | One-cycle calibration start pulse |
| gain_clear | output | 1 | One-cycle strobe clearing the gain bytes |
| soft_mute | output | NCH | Per-channel unity-gain grounded-input mode |
| seq_state | output | 3 | Sequencer state code |

## Verification
The hardest situation to reach is a mute that waits on zero crossings arriving on different channels in different cycles. The wait must keep a sticky record of each channel and must ignore the gating enable. The stimulus table reaches it by disabling gating first and then pulsing each channel's zero-crossing flag in separate cycles, with an idle cycle between the two pulses. A state change at the first pulse, or one that needs both flags in the same cycle, shows up as a state mismatch. Separate directed runs hold the flags low to measure both time-out paths, and the power-hold length after a supply drop, to the exact cycle.

// File: rtl/mps_pkg.sv
package mps_pkg;

    typedef enum logic [2:0] {
        ST_PHOLD  = 3'd0,
        ST_PCAL   = 3'd1,
        ST_RUN    = 3'd2,
        ST_MWAIT  = 3'd3,
        ST_MCAL   = 3'd4,
        ST_MUTED  = 3'd5,
        ST_UWAIT  = 3'd6
    } mps_state_e;

    function automatic logic mps_is_disconnected(input mps_state_e s);
        return (s != ST_RUN) && (s != ST_MWAIT);
    endfunction

endpackage

// File: rtl/mps_cycle_timer.sv
module mps_cycle_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic hit
);
    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign hit = (cnt_q == LAST);

endmodule

// File: rtl/mps_softmute_gate.sv
module mps_softmute_gate #(
    parameter int unsigned GAIN_W  = 8,
    parameter int unsigned TIMEOUT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              force_mute,
    input  logic              gate_en,
    input  logic              zc,
    input  logic [GAIN_W-1:0] gain,
    output logic              soft_mute
);
    logic target;
    logic pending;
    logic to_hit;
    logic apply;
    logic mute_d, mute_q;

    assign target  = (gain == '0);
    assign pending = (target != mute_q);

    mps_cycle_timer #(.LIMIT(TIMEOUT)) u_to (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!pending || force_mute),
        .hit   (to_hit)
    );

    assign apply = pending && (!gate_en || zc || to_hit);

    always_comb begin
        mute_d = mute_q;
        if (force_mute) begin
            mute_d = 1'b1;
        end else if (apply) begin
            mute_d = target;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mute_q <= 1'b1;
        end else begin
            mute_q <= mute_d;
        end
    end

    assign soft_mute = mute_q;

endmodule

// File: rtl/mps_sequencer.sv
module mps_sequencer
    import mps_pkg::*;
#(
    parameter int unsigned NCH        = 2,
    parameter int unsigned GAIN_W     = 8,
    parameter int unsigned PUP_CYCLES = 12_500_000,
    parameter int unsigned ZC_TIMEOUT = 2_000_000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  supply_ok,
    input  logic                  hw_mute,
    input  logic                  zc_gate_en,
    input  logic [NCH-1:0]        zc_det,
    input  logic [NCH*GAIN_W-1:0] gain_bytes,
    input  logic                  cal_done,
    output logic                  out_disconnect,
    output logic                  cal_start,
    output logic                  gain_clear,
    output logic [NCH-1:0]        soft_mute,
    output logic [2:0]            seq_state
);
    typedef struct packed {
        mps_state_e     state;
        logic [NCH-1:0] zc_seen;
        logic           cal_start;
        logic           gain_clear;
    } seq_regs_t;

    localparam seq_regs_t REGS_RST = '{
        state:      ST_PHOLD,
        zc_seen:    '0,
        cal_start:  1'b0,
        gain_clear: 1'b0
    };

    seq_regs_t r_d, r_q;
    logic      pup_hit;
    logic      wait_hit;
    logic      state_change;
    logic      timer_clear;
    logic      zc_all;

    mps_cycle_timer #(.LIMIT(PUP_CYCLES)) u_pup_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (timer_clear),
        .hit   (pup_hit)
    );

    mps_cycle_timer #(.LIMIT(ZC_TIMEOUT)) u_wait_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (timer_clear),
        .hit   (wait_hit)
    );

    assign zc_all = &(r_q.zc_seen | zc_det);

    always_comb begin
        r_d            = r_q;
        r_d.cal_start  = 1'b0;
        r_d.gain_clear = 1'b0;

        case (r_q.state)
            ST_PHOLD: begin
                if (pup_hit) r_d.state = ST_PCAL;
            end
            ST_PCAL: begin
                if (cal_done) r_d.state = ST_RUN;
            end
            ST_RUN: begin
                if (hw_mute) r_d.state = ST_MWAIT;
            end
            ST_MWAIT: begin
                if (!hw_mute)                r_d.state = ST_RUN;
                else if (zc_all || wait_hit) r_d.state = ST_MCAL;
            end
            ST_MCAL: begin
                if (cal_done) r_d.state = ST_MUTED;
            end
            ST_MUTED: begin
                if (!hw_mute) r_d.state = ST_UWAIT;
            end
            ST_UWAIT: begin
                if (hw_mute)                 r_d.state = ST_MUTED;
                else if (zc_all || wait_hit) r_d.state = ST_RUN;
            end
            default: r_d.state = ST_PHOLD;
        endcase

        // loss of supply overrides every transition above
        if (!supply_ok) r_d.state = ST_PHOLD;

        state_change = (r_d.state != r_q.state);

        if (state_change) begin
            r_d.zc_seen = '0;
        end else if (r_q.state == ST_MWAIT || r_q.state == ST_UWAIT) begin
            r_d.zc_seen = r_q.zc_seen | zc_det;
        end

        if (state_change && (r_d.state == ST_PCAL || r_d.state == ST_MCAL)) begin
            r_d.cal_start = 1'b1;
        end
        if (state_change && r_q.state == ST_PCAL && r_d.state == ST_RUN) begin
            r_d.gain_clear = 1'b1;
        end

        timer_clear = state_change || !supply_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    genvar ch;
    generate
        for (ch = 0; ch < NCH; ch++) begin : g_ch
            mps_softmute_gate #(
                .GAIN_W  (GAIN_W),
                .TIMEOUT (ZC_TIMEOUT)
            ) u_gate (
                .clk        (clk),
                .rst_n      (rst_n),
                .force_mute (r_q.state == ST_PHOLD),
                .gate_en    (zc_gate_en),
                .zc         (zc_det[ch]),
                .gain       (gain_bytes[ch*GAIN_W +: GAIN_W]),
                .soft_mute  (soft_mute[ch])
            );
        end
    endgenerate

    assign out_disconnect = mps_is_disconnected(r_q.state);
    assign cal_start      = r_q.cal_start;
    assign gain_clear     = r_q.gain_clear;
    assign seq_state      = r_q.state;

endmodule

// File: rtl/mps_sequencer_chk.sv
module mps_sequencer_chk #(
    parameter int unsigned NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           supply_ok,
    input logic           out_disconnect,
    input logic           cal_start,
    input logic           gain_clear,
    input logic [NCH-1:0] soft_mute,
    input logic [2:0]     seq_state
);
    // R8: supply loss lands in the power hold one edge later
    a_r8_supply_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (seq_state == 3'd0) && out_disconnect);

    // R2: calibration start lasts a single cycle
    a_r2_cal_single: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |=> !cal_start);

    // R6: calibration start only appears in a calibration state
    a_r6_cal_state: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |-> (seq_state == 3'd1 || seq_state == 3'd4));

    // R3: gain clear only on the first run cycle after power calibration
    a_r3_clear_after_cal: assert property (@(posedge clk) disable iff (!rst_n)
        gain_clear |-> (seq_state == 3'd2) && ($past(seq_state) == 3'd1));

    // R1: power hold keeps the output disconnected and no strobes
    a_r1_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 3'd0) |-> out_disconnect && !gain_clear);

    // R4: run keeps the output connected
    a_r4_run_connected: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 3'd2) |-> !out_disconnect);

    // R11: soft mutes forced after one cycle of power hold
    a_r11_soft_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 3'd0 && $past(seq_state) == 3'd0) |-> (&soft_mute));

endmodule

bind mps_sequencer mps_sequencer_chk #(.NCH(NCH)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .supply_ok      (supply_ok),
    .out_disconnect (out_disconnect),
    .cal_start      (cal_start),
    .gain_clear     (gain_clear),
    .soft_mute      (soft_mute),
    .seq_state      (seq_state)
);

// File: tb/mps_sequencer_bench.sv
`timescale 1ns/1ps
module mps_sequencer_bench;
    localparam int unsigned NCH = 2;
    localparam int unsigned GW  = 8;
    localparam int unsigned PUP = 20;
    localparam int unsigned TO  = 10;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            supply_ok;
    logic            hw_mute;
    logic            zc_gate_en;
    logic [NCH-1:0]  zc_det;
    logic [NCH*GW-1:0] gain_bytes;
    logic            cal_done;
    logic            out_disconnect;
    logic            cal_start;
    logic            gain_clear;
    logic [NCH-1:0]  soft_mute;
    logic [2:0]      seq_state;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    mps_sequencer #(
        .NCH(NCH), .GAIN_W(GW), .PUP_CYCLES(PUP), .ZC_TIMEOUT(TO)
    ) u_mps_sequencer (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .hw_mute(hw_mute),
        .zc_gate_en(zc_gate_en), .zc_det(zc_det), .gain_bytes(gain_bytes),
        .cal_done(cal_done), .out_disconnect(out_disconnect),
        .cal_start(cal_start), .gain_clear(gain_clear),
        .soft_mute(soft_mute), .seq_state(seq_state)
    );

    // fields: supply, hw_mute, zc[1:0], cal_done | exp state[2:0], exp disconnect, exp cal_start
    localparam logic [9:0] VEC [12] = '{
        10'b1_1_00_0_011_0_0,
        10'b1_1_01_0_011_0_0,
        10'b1_1_00_0_011_0_0,
        10'b1_1_10_0_100_1_1,
        10'b1_1_00_1_101_1_0,
        10'b1_1_00_0_101_1_0,
        10'b1_0_00_0_110_1_0,
        10'b1_0_01_0_110_1_0,
        10'b1_0_10_0_010_0_0,
        10'b1_1_00_0_011_0_0,
        10'b1_0_00_0_010_0_0,
        10'b0_0_00_0_000_1_0
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 9, 10:   return "R4";
            1, 2, 3:    return "R5";
            4, 5:       return "R6";
            6, 7, 8:    return "R7";
            default:    return "R8";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_state(input logic [2:0] target, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (seq_state != target && n < 1000);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #1_600_000;
        fails++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
    end

    initial begin
        int n;
        rst_n = 1'b0; supply_ok = 1'b1; hw_mute = 1'b0; zc_gate_en = 1'b1;
        zc_det = '0; gain_bytes = '0; cal_done = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "reset state", seq_state, 0);
        chk("R1", "reset disconnect", out_disconnect, 1);
        chk("R1", "reset cal_start", cal_start, 0);
        chk("R1", "reset gain_clear", gain_clear, 0);
        chk("R1", "reset soft_mute", soft_mute, 3);

        rst_n = 1'b1;
        wait_state(3'd1, n);
        chk("R1", "power hold length", n, PUP);
        chk("R2", "cal_start first cycle", cal_start, 1);
        @(negedge clk);
        chk("R2", "cal_start drops", cal_start, 0);
        chk("R2", "still calibrating", seq_state, 1);
        cal_done = 1'b1;
        @(negedge clk);
        cal_done = 1'b0;
        chk("R3", "run after cal", seq_state, 2);
        chk("R3", "gain_clear pulse", gain_clear, 1);
        chk("R3", "connected", out_disconnect, 0);
        @(negedge clk);
        chk("R3", "gain_clear single", gain_clear, 0);

        // table walk with zero-crossing gating off: hardware mute must still wait
        zc_gate_en = 1'b0;
        for (int i = 0; i < 12; i++) begin
            supply_ok = VEC[i][9];
            hw_mute   = VEC[i][8];
            zc_det    = VEC[i][7:6];
            cal_done  = VEC[i][5];
            @(negedge clk);
            chk(vec_tag(i), $sformatf("vec %0d state", i), seq_state, VEC[i][4:2]);
            chk(vec_tag(i), $sformatf("vec %0d disconnect", i), out_disconnect, VEC[i][1]);
            chk(vec_tag(i), $sformatf("vec %0d cal_start", i), cal_start, VEC[i][0]);
        end
        zc_det = '0; cal_done = 1'b0;

        // R8: hold while supply is low, then full restart
        repeat (3) @(negedge clk);
        chk("R8", "held in power hold", seq_state, 0);
        supply_ok = 1'b1;
        wait_state(3'd1, n);
        chk("R8", "restart hold length", n, PUP);
        chk("R8", "restart cal_start", cal_start, 1);
        cal_done = 1'b1;
        @(negedge clk);
        cal_done = 1'b0;
        chk("R8", "back to run", seq_state, 2);

        // R5 time-out path
        hw_mute = 1'b1;
        @(negedge clk);
        chk("R5", "pending", seq_state, 3);
        wait_state(3'd4, n);
        chk("R5", "mute time-out", n, TO);
        cal_done = 1'b1;
        @(negedge clk);
        cal_done = 1'b0;
        chk("R6", "muted", seq_state, 5);
        // R7 re-assert in unmute pending, then time-out release
        hw_mute = 1'b0;
        @(negedge clk);
        chk("R7", "unmute pending", seq_state, 6);
        hw_mute = 1'b1;
        @(negedge clk);
        chk("R7", "re-mute", seq_state, 5);
        hw_mute = 1'b0;
        @(negedge clk);
        wait_state(3'd2, n);
        chk("R7", "unmute time-out", n, TO);
        chk("R7", "reconnected", out_disconnect, 0);

        // R9 software mute with gating on
        zc_gate_en = 1'b1;
        chk("R9", "both soft muted", soft_mute, 3);
        gain_bytes[GW-1:0] = 8'h40;
        @(negedge clk);
        chk("R9", "waits for zc", soft_mute, 3);
        zc_det = 2'b01;
        @(negedge clk);
        zc_det = '0;
        chk("R9", "ch0 unmuted at zc", soft_mute, 2);
        gain_bytes[2*GW-1:GW] = 8'h05;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (soft_mute[1] && n < 1000);
        chk("R9", "ch1 time-out", n, TO);

        // R10 gating off applies at next edge
        zc_gate_en = 1'b0;
        gain_bytes[GW-1:0] = 8'h00;
        @(negedge clk);
        chk("R10", "immediate soft mute", soft_mute, 1);

        // R11 forced in power hold
        supply_ok = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11", "forced soft mute", soft_mute, 3);
        chk("R11", "state hold", seq_state, 0);

        summary();
    end
endmodule